// File: doc/BRIEF.md
# Byte-Synchronous Link Chip-Select Adapter

This block lets a standard SPI slave port take part in a byte-synchronous serial link driven by a radio module. The module clocks data in SPI mode 3: the clock idles high, data changes on the falling edge and is sampled on the rising edge, and each byte goes least-significant bit first. The module's own enable line is not usable as a chip-select, because it drops at the start of the last byte of a transaction, not after it. A slave port that sees it drop would abandon the transfer and lose the trailing checksum byte.

The adapter brings the module's enable, clock and data into the system clock domain through two-flop synchronizers. It counts serial clock rising edges to find byte boundaries, and it drives its own chip-select. That chip-select falls when the enable falls and is released only when a byte ends after the enable has dropped. The adapter also captures each byte and presents it either in link order or bit-reversed, for ports that can only shift MSB-first. On a strobe from the host at the end of each byte, it produces the fixed-width, active-low ready pulse that the module waits for before each byte.

Top module: `bsync_cs_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `spi_cs_n` and `link_rdy_n` are 1 and `byte_valid` is 0.
- R2: When chip-select is idle and has been high for at least one full clock cycle, a falling edge on `link_en_n` drives `spi_cs_n` low no more than 4 clock cycles after the pin changes.
- R3: If `link_en_n` rises before the first bit of a byte, `spi_cs_n` stays low through every bit of that byte. It returns to 1 no more than 4 clock cycles after that byte's eighth rising edge of `link_sclk`, in the same cycle that `byte_valid` is 1.
- R4: If `link_en_n` rises partway through a byte, `spi_cs_n` stays low until the eighth rising edge of that byte. It is then released within 4 clock cycles.
- R5: After `spi_cs_n` rises, it stays high for at least one more clock cycle before it can fall again.
- R6: Rising edges of `link_sclk` while `spi_cs_n` is high produce no `byte_valid` and do not shift the byte alignment of the next transaction.
- R7: After every 8 rising edges of `link_sclk` while chip-select is active, `byte_valid` is 1 for exactly one cycle. With `REVERSE`=0, `byte_out` bit i then equals the i-th data bit sampled in that byte, with the first bit in bit 0.
- R8: With `REVERSE`=1, `byte_out` bit 7-i equals the i-th data bit sampled in the byte (MSB-first presentation of the same byte).
- R9: A one-cycle `rdy_req` strobe while no pulse is running drives `link_rdy_n` low from the next cycle, for exactly `PULSE_CYC` cycles. `PULSE_CYC` is the number of clock cycles that covers `PULSE_NS` at `CLK_HZ`, rounded up (500 at the defaults).
- R10: A `rdy_req` strobe while `link_rdy_n` is low does not lengthen or restart the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sclk | input | 1 | Serial clock from the radio module, idles high |
| link_sdata | input | 1 | Serial data from the module, LSB first |
| link_en_n | input | 1 | Module enable, active low, drops early on the last byte |
| rdy_req | input | 1 | Host strobe at end of byte, requests a ready pulse |
| spi_cs_n | output | 1 | SPI-compliant chip-select to the slave port, active low |
| link_rdy_n | output | 1 | Timed ready pulse to the module, active low |
| byte_out | output | BYTE_W | Captured byte, in link order or reversed |
| byte_valid | output | 1 | One-cycle strobe marking a new byte_out |

## Verification
Random transactions of one to five random bytes are sent with the enable dropped either just before the final byte or at a random bit inside it. Comparing the two cases separates a release that waits for the byte boundary from one that follows the enable directly. Stray clock pulses before a transaction show whether the bit counter is cleared while idle. A second instance built with reversal checks the MSB-first path against the same stream. Ready requests are issued alone, in the middle of a running pulse, and after a pulse ends, which distinguishes correct width from retriggering.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    // Synchronized view of the link pins
    typedef struct packed {
        logic en_n;
        logic sclk;
        logic sdata;
    } link_sig_t;

    typedef enum logic {
        CS_IDLE   = 1'b0,
        CS_ACTIVE = 1'b1
    } cs_state_e;

    // Clock cycles needed to cover ns nanoseconds at clk_hz, rounded up
    function automatic int pulse_cycles(longint clk_hz, longint ns);
        longint prod;
        prod = (clk_hz / 1000) * ns;
        return int'((prod + 999_999) / 1_000_000);
    endfunction

endpackage

// File: rtl/bsync_sync.sv
module bsync_sync
    import bsync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  link_sig_t pin_i,
    output link_sig_t sync_o
);
    link_sig_t chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= '{en_n: 1'b1, sclk: 1'b1, sdata: 1'b0};
            end
        end else begin
            chain[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bsync_byte_rx.sv
module bsync_byte_rx #(
    parameter int BYTE_W  = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              cs_active,
    output logic              wrap_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o
);
    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic              sclk_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_sh;
    logic [BYTE_W-1:0] presented;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign next_sh   = {sdata_s, shreg[BYTE_W-1:1]};
    assign wrap_o    = sclk_rise & cs_active & (bit_cnt == LAST);

    generate
        if (REVERSE) begin : g_rev
            for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
                assign presented[i] = next_sh[BYTE_W-1-i];
            end
        end else begin : g_fwd
            assign presented = next_sh;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            sclk_q  <= sclk_s;
            valid_o <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= next_sh;
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    byte_o  <= presented;
                    valid_o <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bsync_cs_ctrl.sv
module bsync_cs_ctrl
    import bsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n_s,
    input  logic wrap,
    output logic cs_active
);
    cs_state_e state;
    logic      en_q;
    logic      en_fall;
    logic      en_rise;
    logic      pending;
    logic      idle_seen;

    assign en_fall   = en_q & ~en_n_s;
    assign en_rise   = ~en_q & en_n_s;
    assign cs_active = (state == CS_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CS_IDLE;
            en_q      <= 1'b1;
            pending   <= 1'b0;
            idle_seen <= 1'b0;
        end else begin
            en_q <= en_n_s;
            unique case (state)
                CS_IDLE: begin
                    idle_seen <= 1'b1;
                    if (idle_seen && en_fall) begin
                        state     <= CS_ACTIVE;
                        pending   <= 1'b0;
                        idle_seen <= 1'b0;
                    end
                end
                CS_ACTIVE: begin
                    if (wrap && pending) begin
                        state   <= CS_IDLE;
                        pending <= 1'b0;
                    end else if (en_rise) begin
                        pending <= 1'b1;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bsync_rdy_pulse.sv
module bsync_rdy_pulse #(
    parameter int PULSE_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy
);
    localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CW-1:0] END_CNT = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (req) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (cnt == END_CNT) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bsync_cs_adapter.sv
module bsync_cs_adapter
    import bsync_pkg::*;
#(
    parameter int     BYTE_W   = 8,
    parameter bit     REVERSE  = 1'b0,
    parameter int     SYNC_STG = 2,
    parameter longint CLK_HZ   = 200_000_000,
    parameter longint PULSE_NS = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_sclk,
    input  logic              link_sdata,
    input  logic              link_en_n,
    input  logic              rdy_req,
    output logic              spi_cs_n,
    output logic              link_rdy_n,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid
);
    localparam int PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_NS);

    link_sig_t pins;
    link_sig_t synced;
    logic      cs_active;
    logic      wrap;
    logic      rdy_busy;

    assign pins = '{en_n: link_en_n, sclk: link_sclk, sdata: link_sdata};

    bsync_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pins),
        .sync_o (synced)
    );

    bsync_byte_rx #(.BYTE_W(BYTE_W), .REVERSE(REVERSE)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (synced.sclk),
        .sdata_s   (synced.sdata),
        .cs_active (cs_active),
        .wrap_o    (wrap),
        .byte_o    (byte_out),
        .valid_o   (byte_valid)
    );

    bsync_cs_ctrl cs_i (
        .clk       (clk),
        .rst       (rst),
        .en_n_s    (synced.en_n),
        .wrap      (wrap),
        .cs_active (cs_active)
    );

    bsync_rdy_pulse #(.PULSE_CYC(PULSE_CYC)) rdy_i (
        .clk  (clk),
        .rst  (rst),
        .req  (rdy_req),
        .busy (rdy_busy)
    );

    assign spi_cs_n   = ~cs_active;
    assign link_rdy_n = ~rdy_busy;
endmodule

// File: rtl/bsync_cs_adapter_chk.sv
module bsync_cs_adapter_chk #(
    parameter int PULSE_CYC = 500
) (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic link_rdy_n,
    input logic byte_valid
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || link_rdy_n) low_run <= '0;
        else                   low_run <= low_run + 1;
    end

    // R5
    cs_min_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);

    // R3
    cs_release_at_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> byte_valid);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R7
    valid_only_active_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !$rose(spi_cs_n)) |-> !spi_cs_n);

    // R9
    rdy_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_rdy_n) |-> (low_run == 32'(PULSE_CYC)));

    // R10
    rdy_no_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        !link_rdy_n |-> (low_run < 32'(PULSE_CYC)));
endmodule

bind bsync_cs_adapter bsync_cs_adapter_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .spi_cs_n   (spi_cs_n),
    .link_rdy_n (link_rdy_n),
    .byte_valid (byte_valid)
);

// File: tb/bsync_cs_adapter_tb_top.sv
module bsync_cs_adapter_tb_top;
    localparam int H     = 6;
    localparam int PULSE = 500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       sdata = 1'b0;
    logic       en_n = 1'b1;
    logic       req = 1'b0;
    logic       cs_n, rdy_n, valid;
    logic [7:0] bout;
    logic       cs_n_r, rdy_n_r, valid_r;
    logic [7:0] bout_r;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] got_f [$];
    logic [7:0] got_r [$];

    always #2.5 clk = ~clk;

    bsync_cs_adapter #(.REVERSE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .link_sclk(sclk), .link_sdata(sdata),
        .link_en_n(en_n), .rdy_req(req), .spi_cs_n(cs_n),
        .link_rdy_n(rdy_n), .byte_out(bout), .byte_valid(valid));

    bsync_cs_adapter #(.REVERSE(1'b1)) dut_rev_i (
        .clk(clk), .rst(rst), .link_sclk(sclk), .link_sdata(sdata),
        .link_en_n(en_n), .rdy_req(req), .spi_cs_n(cs_n_r),
        .link_rdy_n(rdy_n_r), .byte_out(bout_r), .byte_valid(valid_r));

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic check(bit ok, string req_tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst && valid)   got_f.push_back(bout);
        if (!rst && valid_r) got_r.push_back(bout_r);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    // One transaction; drop_bit 0 = enable drops before the last byte,
    // 1..7 = enable drops at that bit of the last byte
    task automatic run_txn(int nbytes, int drop_bit, bit stray);
        logic [7:0] data [8];
        if (stray) begin
            for (int k = 0; k < 3; k++) begin
                sclk = 1'b0; waitn(H); sclk = 1'b1; waitn(H);
            end
            // R6: no byte produced while idle
            check(got_f.size() == 0, "R6", got_f.size(), 0);
        end
        for (int b = 0; b < nbytes; b++) data[b] = 8'($urandom);
        en_n = 1'b0;
        waitn(4);
        // R2
        check(cs_n == 1'b0 && cs_n_r == 1'b0, "R2", cs_n, 0);
        waitn(H);
        for (int b = 0; b < nbytes; b++) begin
            bit last;
            last = (b == nbytes - 1);
            if (last && drop_bit == 0) begin
                en_n = 1'b1;
                waitn(H);
            end
            for (int i = 0; i < 8; i++) begin
                if (last && i == 7) begin
                    if (drop_bit == 0) check(cs_n == 1'b0, "R3", cs_n, 0);
                    else               check(cs_n == 1'b0, "R4", cs_n, 0);
                end
                sclk = 1'b0;
                sdata = data[b][i];
                if (last && drop_bit != 0 && i == drop_bit) en_n = 1'b1;
                waitn(H);
                sclk = 1'b1;
                waitn(H);
            end
        end
        if (drop_bit == 0) check(cs_n == 1'b1 && cs_n_r == 1'b1, "R3", cs_n, 1);
        else               check(cs_n == 1'b1 && cs_n_r == 1'b1, "R4", cs_n, 1);
        check(got_f.size() == nbytes, "R7", got_f.size(), nbytes);
        check(got_r.size() == nbytes, "R8", got_r.size(), nbytes);
        for (int b = 0; b < nbytes; b++) begin
            if (got_f.size() > 0) begin
                logic [7:0] g;
                g = got_f.pop_front();
                check(g == data[b], "R7", g, data[b]);
            end
            if (got_r.size() > 0) begin
                logic [7:0] g;
                g = got_r.pop_front();
                check(g == rev8(data[b]), "R8", g, rev8(data[b]));
            end
        end
        got_f.delete();
        got_r.delete();
        waitn(10);
    endtask

    task automatic measure_pulse(int retrig_at, string tag);
        int low;
        low = 0;
        req = 1'b1; waitn(1); req = 1'b0;
        for (int c = 0; c < PULSE + 100; c++) begin
            if (c == retrig_at) req = 1'b1;
            if (c == retrig_at + 1) req = 1'b0;
            if (rdy_n == 1'b0) low++;
            waitn(1);
        end
        check(low == PULSE, tag, low, PULSE);
    endtask

    initial begin
        void'($urandom(32'd7351));
        waitn(3);
        // R1
        check(cs_n == 1 && rdy_n == 1 && valid == 0, "R1", cs_n, 1);
        rst = 1'b0;
        waitn(1);
        check(cs_n == 1 && rdy_n == 1 && valid == 0, "R1", rdy_n, 1);
        waitn(5);

        // Directed corners
        run_txn(1, 0, 1'b0);
        run_txn(1, 3, 1'b0);
        run_txn(3, 7, 1'b1);
        run_txn(2, 1, 1'b1);

        // Random transactions
        for (int t = 0; t < 16; t++) begin
            int nb, db;
            nb = 1 + int'($urandom % 5);
            db = int'($urandom % 8);
            run_txn(nb, db, 1'($urandom % 2));
        end

        // R9: single pulse, first low cycle right after the strobe
        req = 1'b1; waitn(1); req = 1'b0;
        check(rdy_n == 1'b0, "R9", rdy_n, 0);
        waitn(PULSE + 20);
        measure_pulse(-5, "R9");
        // R10: request in the middle of a running pulse
        measure_pulse(100, "R10");
        measure_pulse(PULSE - 3, "R10");

        done = 1'b1;
        finish_run();
    end
endmodule